// File: doc/BRIEF.md
# Graphics Engine Interrupt and Status Unit

This block sits beside a 2D drawing engine and its command FIFO. It samples four event conditions: drawing finished, engine idle, FIFO overflow, and FIFO fill count equal to a programmed threshold. It shows the sampled engine state in a read-only status word. It turns the rising edge of each condition into an interrupt event.

Software reaches four 32-bit words over a simple register bus. The bus takes a write strobe and a 2-bit word address, and read data is returned combinationally.

A mode bit in the pending word chooses how events are signalled. In level mode, events latch into pending bits, and each pending bit stays set until software writes 1 to it. The interrupt line is the OR of pending bits that are enabled. In pulse mode, no pending state is kept. Each enabled event raises the interrupt line for exactly one clock.

Top module: `gfx_irq_unit`

## Requirements
- R1: After reset the status word (address 0) reads 0x0000_0600, the pending word (address 1), enable word (address 2) and threshold word (address 3) read 0, and irq_o is low.
- R2: The status word reports the sampled drawing-finished input at bit 10, idle at bit 9, overflow at bit 8 and the FIFO used count at bits 5:0, one clock after the inputs are presented; writes to it have no effect.
- R3: In the pending word bit 31 is the mode (1 level, 0 pulse), drawing-finished is bit 10, idle bit 9, overflow bit 8 and FIFO-level bit 0; bits 30:11 and 7:1 read as zero.
- R4: In level mode a 0-to-1 change of the drawing-finished, idle or overflow input sets its pending bit at the clock edge that samples the change.
- R5: The FIFO-level source fires only on the clock where the used count first equals the threshold (address 3, bits 5:0); a count that stays equal does not fire again, and the match present at reset does not fire.
- R6: In level mode, writing 1 to a pending bit position clears that bit, and writing 0 leaves it unchanged.
- R7: When a clear write and a new event hit the same pending bit on one edge, the bit stays set.
- R8: In level mode irq_o is high exactly while some pending bit has its enable set; the enable word uses bit positions 10, 9, 8 and 0.
- R9: In pulse mode the pending bits read 0, and each enabled event drives irq_o high for exactly the one clock after the edge that samples it.
- R10: A source whose enable bit is 0 never raises irq_o, yet in level mode its pending bit still sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| draw_done_i | input | 1 | Drawing-finished condition from the engine |
| idle_i | input | 1 | Engine idle condition |
| ovf_i | input | 1 | FIFO overflow condition |
| fifo_used_i | input | 6 | Number of used FIFO entries |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data (combinational on address) |
| irq_o | output | 1 | Interrupt output |

## Verification
Each input condition is sampled on one clock edge. After that edge the status bits, the pending bits and the level-mode interrupt are already current. A pulse-mode interrupt is high only during the clock that follows the sampling edge.

The bench drives inputs on the falling edge and steps a behavioural model on the rising edge. It compares irq_o with the model at every falling edge. It reads registers in the low phase, after the edge that must have updated them, so each result is sampled in the cycle it is due.

// File: rtl/gfx_irq_pkg.sv
package gfx_irq_pkg;
  localparam int NSRC     = 4;
  // source vector order
  localparam int SRC_DRAW = 3;
  localparam int SRC_IDLE = 2;
  localparam int SRC_OVF  = 1;
  localparam int SRC_LVL  = 0;
  // register bit positions
  localparam int BIT_MODE = 31;
  localparam int BIT_DRAW = 10;
  localparam int BIT_IDLE = 9;
  localparam int BIT_OVF  = 8;
  localparam int BIT_LVL  = 0;
  // word addresses
  localparam logic [1:0] RA_STAT = 2'd0;
  localparam logic [1:0] RA_PEND = 2'd1;
  localparam logic [1:0] RA_EN   = 2'd2;
  localparam logic [1:0] RA_THR  = 2'd3;

  function automatic logic [NSRC-1:0] word_to_src(input logic [31:0] w);
    logic [NSRC-1:0] s;
    s[SRC_DRAW] = w[BIT_DRAW];
    s[SRC_IDLE] = w[BIT_IDLE];
    s[SRC_OVF]  = w[BIT_OVF];
    s[SRC_LVL]  = w[BIT_LVL];
    return s;
  endfunction

  function automatic logic [31:0] src_to_word(input logic [NSRC-1:0] s);
    logic [31:0] w;
    w = '0;
    w[BIT_DRAW] = s[SRC_DRAW];
    w[BIT_IDLE] = s[SRC_IDLE];
    w[BIT_OVF]  = s[SRC_OVF];
    w[BIT_LVL]  = s[SRC_LVL];
    return w;
  endfunction
endpackage

// File: rtl/gfx_src_sampler.sv
module gfx_src_sampler
  import gfx_irq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             draw_done_i,
  input  logic             idle_i,
  input  logic             ovf_i,
  input  logic [CNT_W-1:0] used_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [NSRC-1:0]  cond_q_o,
  output logic [CNT_W-1:0] used_q_o,
  output logic [NSRC-1:0]  ev_o
);
  // draw/idle high and threshold match assumed at reset: no spurious events
  localparam logic [NSRC-1:0] COND_RST = NSRC'((1 << SRC_DRAW) | (1 << SRC_IDLE) | (1 << SRC_LVL));

  logic [NSRC-1:0] cond;
  logic [NSRC-1:0] cond_q;

  always_comb begin
    cond           = '0;
    cond[SRC_DRAW] = draw_done_i;
    cond[SRC_IDLE] = idle_i;
    cond[SRC_OVF]  = ovf_i;
    cond[SRC_LVL]  = (used_i == thr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q   <= COND_RST;
      used_q_o <= '0;
    end else begin
      cond_q   <= cond;
      used_q_o <= used_i;
    end
  end

  assign ev_o     = cond & ~cond_q;
  assign cond_q_o = cond_q;

  // R4 R5: an event marks a condition that is held high on the next cycle
  a_r5_edge_then_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev_o) |=> ((cond_q & $past(ev_o)) == $past(ev_o)));
endmodule

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl
  import gfx_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] ev_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o,
  output logic            irq_o
);
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_d;
  logic            pulse_q;

  // set has priority over clear
  assign pend_d = mode_i ? ((pend_q & ~clr_i) | ev_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      pulse_q <= |(ev_i & en_i);
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = mode_i ? |(pend_q & en_i) : pulse_q;

  a_r6_hold_until_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |=> (((pend_q | $past(clr_i)) & $past(pend_q)) == $past(pend_q)));
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |=> ((pend_q & $past(ev_i)) == $past(ev_i)));
  a_r9_no_pend_in_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> (pend_q == '0));
  a_r9_pulse_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && irq_o) |-> $past(|(ev_i & en_i)));
endmodule

// File: rtl/gfx_irq_unit.sv
module gfx_irq_unit
  import gfx_irq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             draw_done_i,
  input  logic             idle_i,
  input  logic             ovf_i,
  input  logic [CNT_W-1:0] fifo_used_i,
  input  logic             bus_wr_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  output logic             irq_o
);
  logic             mode_q;
  logic [NSRC-1:0]  en_q;
  logic [CNT_W-1:0] thr_q;
  logic [NSRC-1:0]  cond_q;
  logic [CNT_W-1:0] used_q;
  logic [NSRC-1:0]  ev;
  logic [NSRC-1:0]  pend;
  logic [NSRC-1:0]  clr;
  logic             wr_pend;
  logic             unused_wdata;

  assign wr_pend      = bus_wr_i && (bus_addr_i == RA_PEND);
  assign clr          = (wr_pend && mode_q) ? word_to_src(bus_wdata_i) : '0;
  assign unused_wdata = ^bus_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (bus_wr_i) begin
      unique case (bus_addr_i)
        RA_PEND: mode_q <= bus_wdata_i[BIT_MODE];
        RA_EN:   en_q   <= word_to_src(bus_wdata_i);
        RA_THR:  thr_q  <= bus_wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  gfx_src_sampler #(.CNT_W(CNT_W)) u_smp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .draw_done_i(draw_done_i),
    .idle_i     (idle_i),
    .ovf_i      (ovf_i),
    .used_i     (fifo_used_i),
    .thr_i      (thr_q),
    .cond_q_o   (cond_q),
    .used_q_o   (used_q),
    .ev_o       (ev)
  );

  gfx_irq_ctrl u_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode_q),
    .en_i  (en_q),
    .ev_i  (ev),
    .clr_i (clr),
    .pend_o(pend),
    .irq_o (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      RA_STAT: begin
        bus_rdata_o[BIT_DRAW]  = cond_q[SRC_DRAW];
        bus_rdata_o[BIT_IDLE]  = cond_q[SRC_IDLE];
        bus_rdata_o[BIT_OVF]   = cond_q[SRC_OVF];
        bus_rdata_o[CNT_W-1:0] = used_q;
      end
      RA_PEND: begin
        bus_rdata_o           = src_to_word(pend);
        bus_rdata_o[BIT_MODE] = mode_q;
      end
      RA_EN:   bus_rdata_o = src_to_word(en_q);
      default: bus_rdata_o[CNT_W-1:0] = thr_q;
    endcase
  end

  a_r3_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[30:11] == '0);
  a_r8_level_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && irq_o) |-> |(pend & en_q));
endmodule

// File: tb/tb_gfx_irq_unit.sv
module tb_gfx_irq_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        draw = 1'b1, idle = 1'b1, ovf = 1'b0;
  logic [5:0]  used = '0;
  logic        wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state, bit order {draw, idle, ovf, level}
  bit       m_mode;
  bit [3:0] m_en, m_pend, m_prev;
  bit [5:0] m_thr, m_used;
  bit       m_pulse;

  gfx_irq_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .draw_done_i(draw), .idle_i(idle), .ovf_i(ovf),
    .fifo_used_i(used), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit [3:0] pick(input bit [31:0] w);
    return {w[10], w[9], w[8], w[0]};
  endfunction
  function automatic bit [31:0] spread(input bit [3:0] s);
    bit [31:0] w = '0;
    w[10] = s[3]; w[9] = s[2]; w[8] = s[1]; w[0] = s[0];
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_en = 0; m_pend = 0; m_prev = 4'b1101;
      m_thr = 0; m_used = 0; m_pulse = 0;
    end else begin
      bit [3:0] cond, ev, clr;
      cond = {draw, idle, ovf, (used == m_thr)};
      ev   = cond & ~m_prev;
      clr  = (wr && addr == 2'd1 && m_mode) ? pick(wdata) : 4'b0;
      m_pend  = m_mode ? ((m_pend & ~clr) | ev) : 4'b0;
      m_pulse = |(ev & m_en);
      m_prev  = cond;
      m_used  = used;
      if (wr) begin
        case (addr)
          2'd1: m_mode = wdata[31];
          2'd2: m_en   = pick(wdata);
          2'd3: m_thr  = wdata[5:0];
          default: ;
        endcase
      end
    end
  end

  function automatic bit [31:0] m_read(input bit [1:0] a);
    bit [31:0] w = '0;
    case (a)
      2'd0: begin w = spread({m_prev[3:1], 1'b0}); w[5:0] = m_used; end
      2'd1: begin w = spread(m_pend); w[31] = m_mode; end
      2'd2: w = spread(m_en);
      default: w[5:0] = m_thr;
    endcase
    return w;
  endfunction

  // per-cycle interrupt comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_irq;
      exp_irq = m_mode ? |(m_pend & m_en) : m_pulse;
      checks++;
      if (irq !== exp_irq) begin
        fails++;
        $display("FAIL R8|R9 irq_o at %0t: actual %0b expected %0b", $time, irq, exp_irq);
      end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input bit [1:0] a, input bit [31:0] d);
    @(negedge clk);
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0; wdata = '0;
  endtask

  task automatic rreg(input bit [1:0] a, input string tag);
    addr = a;
    #1;
    checks++;
    if (rdata !== m_read(a)) begin
      fails++;
      $display("FAIL %s read addr %0d: actual %h expected %h", tag, a, rdata, m_read(a));
    end
  endtask

  task automatic rexp(input bit [1:0] a, input bit [31:0] exp, input string tag);
    addr = a;
    #1;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s read addr %0d: actual %h expected %h", tag, a, rdata, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    // R1 reset values
    rexp(2'd0, 32'h0000_0600, "R1");
    rexp(2'd1, 32'h0, "R1");
    rexp(2'd2, 32'h0, "R1");
    rexp(2'd3, 32'h0, "R1");
    checks++;
    if (irq !== 1'b0) begin fails++; $display("FAIL R1 irq_o actual %0b expected 0", irq); end

    // R2 status tracks inputs, writes ignored
    draw = 0; idle = 0; ovf = 1; used = 6'd17;
    tick();
    rexp(2'd0, 32'h0000_0111, "R2");
    wreg(2'd0, 32'hFFFF_FFFF);
    rexp(2'd0, 32'h0000_0111, "R2");
    ovf = 0; used = 6'd0;
    tick();

    // level mode, enable draw, idle, level
    wreg(2'd1, 32'h8000_0000);
    wreg(2'd2, 32'h0000_0601);
    rexp(2'd2, 32'h0000_0601, "R8");
    draw = 1;
    tick();
    rexp(2'd1, 32'h8000_0400, "R4");
    tick(2);
    rreg(2'd1, "R6");
    wreg(2'd1, 32'h8000_0000);  // writing 0 keeps bit
    rexp(2'd1, 32'h8000_0400, "R6");
    wreg(2'd1, 32'h8000_0400);  // write 1 clears
    rexp(2'd1, 32'h8000_0000, "R6");

    // R7 clear and set together
    @(negedge clk);
    idle = 1; wr = 1; addr = 2'd1; wdata = 32'h8000_0200;
    @(negedge clk);
    wr = 0; wdata = '0;
    rexp(2'd1, 32'h8000_0200, "R7");
    wreg(2'd1, 32'h8000_0200);
    rexp(2'd1, 32'h8000_0000, "R6");

    // R10 overflow disabled: pending sets, no irq
    ovf = 1;
    tick();
    rexp(2'd1, 32'h8000_0100, "R10");
    checks++;
    if (irq !== 1'b0) begin fails++; $display("FAIL R10 irq_o actual %0b expected 0", irq); end
    wreg(2'd1, 32'h8000_0100);
    ovf = 0;

    // R5 threshold match edge
    wreg(2'd3, 32'h0000_0005);
    rexp(2'd3, 32'h0000_0005, "R5");
    used = 6'd3; tick();
    used = 6'd4; tick();
    rexp(2'd1, 32'h8000_0000, "R5");
    used = 6'd5; tick();
    rexp(2'd1, 32'h8000_0001, "R5");
    wreg(2'd1, 32'h8000_0001);
    tick(3);
    rexp(2'd1, 32'h8000_0000, "R5");
    used = 6'd6; tick();
    used = 6'd5; tick();
    rexp(2'd1, 32'h8000_0001, "R5");
    wreg(2'd1, 32'h8000_0001);

    // R9 pulse mode
    wreg(2'd1, 32'h0000_0000);
    wreg(2'd2, 32'h0000_0701);
    tick();
    draw = 0; idle = 0; tick();
    draw = 1; tick();
    checks++;
    if (irq !== 1'b1) begin fails++; $display("FAIL R9 pulse irq_o actual %0b expected 1", irq); end
    rexp(2'd1, 32'h0000_0000, "R9");
    tick();
    checks++;
    if (irq !== 1'b0) begin fails++; $display("FAIL R9 pulse end irq_o actual %0b expected 0", irq); end
    idle = 1; ovf = 1; tick();
    idle = 0; ovf = 0; used = 6'd9; tick(2);
    used = 6'd5; tick(3);
    for (int i = 0; i < 40; i++) begin
      draw = i[0]; idle = i[1]; ovf = i[2]; used = 6'(i % 7);
      if (i == 20) wreg(2'd1, 32'h8000_0000);
      tick();
      rreg(2'd1, "R4");
      rreg(2'd0, "R2");
    end
    tick(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule